// File: doc/BRIEF.md
# Three-Address I2C Register Target

This block is an I2C target that gives a host controller byte access to an internal register file. It answers on three 7-bit bus addresses. The main address reaches the general register space. Two auxiliary addresses each reach one small temperature-sensor bank, and nothing else.

The main address is `01011` followed by two strap pins, high strap first. The straps are captured while reset is asserted. The two auxiliary addresses are `1001` followed by a 3-bit field held in a configuration register. The host can rewrite that register through the main address.

Each address keeps its own index pointer. A write frame carries the address byte, an index byte and data bytes. A read sets the index with a short write and then issues a repeated START with the read bit set. After every byte moved, the pointer of the active address advances by one.

SCL and SDA are sampled on a system clock that runs faster than eight times the SCL rate. SDA is driven open-drain through an output enable.

Top module: `i2c_tri_target`

## Requirements
- R1: The main address is {5'b01011, strap_hi, strap_lo}, captured while rst_n is low. Strap changes after reset have no effect. Any other address gets no ACK.
- R2: Through the main address, index 0x48 reads {1'b0, main address}. Writes to index 0x48 are ignored.
- R3: In a write frame (START, address with R/W=0, index, data, STOP), the target pulls SDA low on the ninth clock after each of the three bytes. The data byte lands at the index.
- R4: An address+index write, then a repeated START with R/W=1, returns the byte at the index. The pointer advances after every byte written or read, so bursts reach consecutive indices. A master NACK ends the read with SDA released.
- R5: The second address is {4'b1001, cfg[2:0]}, where cfg is index 0x4A. It reaches only bank A (4 bytes, index taken modulo 4).
- R6: The third address is {4'b1001, cfg[6:4]}. It reaches only bank B (4 bytes, index modulo 4). Bank A and bank B are separate storage.
- R7: Through the main address, bank windows 0x50–0x53 and 0x54–0x57 read 0x00, and writes there change no bank byte.
- R8: After a non-matching address byte, the target gives no ACK and leaves SDA released until the next START.
- R9: After reset, SDA is released, index 0x4A holds 0x21, and every other stored byte is 0x00.
- R10: A new value written to index 0x4A moves the two auxiliary addresses from the next frame on.
- R11: Each address keeps its own pointer across frames. A read frame without an index byte continues from that address's pointer.
- R12: When the two 3-bit fields are equal, that address reaches bank A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, more than 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while low |
| strap_hi | input | 1 | Strap for main-address bit 1 |
| strap_lo | input | 1 | Strap for main-address bit 0 |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |

## Verification
The bench targets the cases where the three views could leak into each other:
- A main-address write into a bank window must leave the bank untouched.
- A bank A write must not show through bank B.
- Equal auxiliary fields must resolve to bank A.

If the views leaked, one address's write would corrupt another view, and the bench's later readback would return the wrong byte.

Other cases:
- **Per-address pointers.** One pointer shared between views would make an index-less read return the wrong byte.
- **Address cases.** The bench uses a non-matching address, strap changes after reset, and a reset with new straps. A target that acked a stranger, or re-sampled its straps, would show up as a wrong ACK bit.
- **Bursts.** A burst write and read with a final NACK must land on consecutive indices and end with SDA released.

// File: rtl/i2ct_pkg.sv
// Shared types for the three-address I2C target.
// Assumes: one active view per frame, chosen by the address byte.
package i2ct_pkg;
    typedef enum logic [1:0] {VIEW_NONE, VIEW_MAIN, VIEW_BANK_A, VIEW_BANK_B} view_e;
    typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_MACK} bus_st_e;
endpackage

// File: rtl/i2ct_line_sync.sv
// Brings SCL/SDA into the clk domain through a flip-flop chain and flags
// SCL edges plus START/STOP conditions.
// Assumes: clk is more than 8x the SCL rate; lines idle high.
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_q, sda_q;

    // synchronizer chains plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    // edge and bus-condition decode
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
    end
endmodule

// File: rtl/i2ct_regs.sv
// Register storage with three views: main (general space, bank windows
// masked, address reg read-only, config reg) and two 4-byte sensor banks.
// Assumes: one write and one read per cycle; index 8 bits wide.
module i2ct_regs
    import i2ct_pkg::*;
#(
    parameter int         GEN_DEPTH = 128,
    parameter int         SB_DEPTH  = 4,
    parameter logic [7:0] BASE_A    = 8'h50,
    parameter logic [7:0] BASE_B    = 8'h54,
    parameter logic [7:0] IDX_ADDR  = 8'h48,
    parameter logic [7:0] IDX_CFG   = 8'h4A,
    parameter logic [7:0] CFG_RST   = 8'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] main_addr,
    input  logic       wr_en,
    input  view_e      wr_view,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  view_e      rd_view,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic [7:0] cfg
);
    localparam int GAW   = $clog2(GEN_DEPTH);
    localparam int SB_AW = $clog2(SB_DEPTH);

    logic [7:0] gen_mem [GEN_DEPTH];
    logic [7:0] bank_a  [SB_DEPTH];
    logic [7:0] bank_b  [SB_DEPTH];
    logic       gen_we, cfg_we, a_we, b_we;
    logic       rd_in_win;

    function automatic logic in_win(input logic [7:0] i, input logic [7:0] b);
        return i[7:SB_AW] == b[7:SB_AW];
    endfunction

    // write-port decode per view
    always_comb begin
        gen_we = wr_en && wr_view == VIEW_MAIN && !in_win(wr_idx, BASE_A)
                 && !in_win(wr_idx, BASE_B) && wr_idx != IDX_ADDR
                 && wr_idx != IDX_CFG && ({1'b0, wr_idx} < 9'(GEN_DEPTH));
        cfg_we = wr_en && wr_view == VIEW_MAIN && wr_idx == IDX_CFG;
        a_we   = wr_en && wr_view == VIEW_BANK_A;
        b_we   = wr_en && wr_view == VIEW_BANK_B;
    end

    // configuration byte holding the auxiliary address fields
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RST;
        else if (cfg_we) cfg <= wr_data;
    end

    for (genvar g = 0; g < GEN_DEPTH; g++) begin : g_gen
        // one general-space byte
        always_ff @(posedge clk) begin
            if (!rst_n)                             gen_mem[g] <= '0;
            else if (gen_we && wr_idx == 8'(g))     gen_mem[g] <= wr_data;
        end
    end

    for (genvar s = 0; s < SB_DEPTH; s++) begin : g_bank
        // one byte of each sensor bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_a[s] <= '0;
                bank_b[s] <= '0;
            end else begin
                if (a_we && wr_idx[SB_AW-1:0] == SB_AW'(s)) bank_a[s] <= wr_data;
                if (b_we && wr_idx[SB_AW-1:0] == SB_AW'(s)) bank_b[s] <= wr_data;
            end
        end
    end

    // read mux per view
    always_comb begin
        rd_in_win = in_win(rd_idx, BASE_A) || in_win(rd_idx, BASE_B);
        rd_data   = '0;
        unique case (rd_view)
            VIEW_MAIN: begin
                if (rd_in_win)                                rd_data = '0;
                else if (rd_idx == IDX_ADDR)                  rd_data = {1'b0, main_addr};
                else if (rd_idx == IDX_CFG)                   rd_data = cfg;
                else if ({1'b0, rd_idx} < 9'(GEN_DEPTH))      rd_data = gen_mem[rd_idx[GAW-1:0]];
            end
            VIEW_BANK_A: rd_data = bank_a[rd_idx[SB_AW-1:0]];
            VIEW_BANK_B: rd_data = bank_b[rd_idx[SB_AW-1:0]];
            default:     rd_data = '0;
        endcase
    end

    // R7
    win_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_view == VIEW_MAIN && rd_in_win) |-> rd_data == 8'h00);
    // R2
    addr_reg_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_view == VIEW_MAIN && rd_idx == IDX_ADDR) |-> rd_data == {1'b0, main_addr});
    // R7
    win_write_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == VIEW_MAIN) |=> $stable(bank_a[0]) && $stable(bank_b[0]));
endmodule

// File: rtl/i2c_tri_target.sv
// I2C target answering on a strap-set main address and two
// register-set auxiliary addresses, each with its own index pointer.
// Assumes: clk > 8x SCL, no clock stretching, master follows the bus rules.
module i2c_tri_target
    import i2ct_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] MAIN_HI     = 5'b01011,
    parameter logic [3:0] AUX_HI      = 4'b1001,
    parameter int         GEN_DEPTH   = 128,
    parameter int         SB_DEPTH    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_hi,
    input  logic strap_lo,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] main_addr;
    logic [7:0] cfg, rd_data, shreg, tx;
    logic [6:0] aux_a, aux_b;
    logic [3:0] bit_cnt;
    logic [7:0] ptr [4];
    bus_st_e    state;
    view_e      view, hit;
    logic       rw, idx_done, nack, wr_en;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2ct_regs #(.GEN_DEPTH(GEN_DEPTH), .SB_DEPTH(SB_DEPTH)) i_regs (
        .clk(clk), .rst_n(rst_n), .main_addr(main_addr),
        .wr_en(wr_en), .wr_view(view), .wr_idx(ptr[view]), .wr_data(shreg),
        .rd_view(view), .rd_idx(ptr[view]), .rd_data(rd_data), .cfg(cfg)
    );

    // strap capture: held open while reset is low, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) main_addr <= {MAIN_HI, strap_hi, strap_lo};
    end

    // address decode of the received address byte (second address wins ties)
    always_comb begin
        aux_a = {AUX_HI, cfg[2:0]};
        aux_b = {AUX_HI, cfg[6:4]};
        if (shreg[7:1] == main_addr)  hit = VIEW_MAIN;
        else if (shreg[7:1] == aux_a) hit = VIEW_BANK_A;
        else if (shreg[7:1] == aux_b) hit = VIEW_BANK_B;
        else                          hit = VIEW_NONE;
    end

    // data-byte write strobe, at the falling edge that ends the 8th bit
    always_comb wr_en = state == ST_RX && scl_fall && bit_cnt == 4'd8 && idx_done && !start_det && !stop_det;

    // bus protocol engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; tx <= '0;
            view <= VIEW_NONE; rw <= 1'b0; idx_done <= 1'b0; nack <= 1'b1;
            sda_oe <= 1'b0;
            for (int i = 0; i < 4; i++) ptr[i] <= '0;
        end else if (start_det) begin
            state <= ST_ADDR; bit_cnt <= '0; idx_done <= 1'b0; sda_oe <= 1'b0;
        end else if (stop_det) begin
            state <= ST_IDLE; sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s}; bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        if (hit != VIEW_NONE) begin
                            view <= hit; rw <= shreg[0]; sda_oe <= 1'b1; state <= ST_ACK;
                        end else state <= ST_IDLE;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    bit_cnt <= '0;
                    if (rw) begin
                        tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0; state <= ST_RX;
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shreg <= {shreg[6:0], sda_s}; bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        sda_oe <= 1'b1; state <= ST_ACK;
                        if (!idx_done) begin
                            ptr[view] <= shreg; idx_done <= 1'b1;
                        end else ptr[view] <= ptr[view] + 8'd1;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (bit_cnt == 4'd7) begin
                        sda_oe <= 1'b0; bit_cnt <= '0; state <= ST_MACK;
                        ptr[view] <= ptr[view] + 8'd1;
                    end else begin
                        tx <= {tx[6:0], 1'b0}; sda_oe <= ~tx[6]; bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) nack <= sda_s;
                    else if (scl_fall) begin
                        if (!nack) begin
                            tx <= rd_data; sda_oe <= ~rd_data[7]; state <= ST_TX;
                        end else state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    main_addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(main_addr));
    // R8
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);
    // R3
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);
    // R4
    nack_ends_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && scl_fall && nack && !start_det && !stop_det) |=> state == ST_IDLE && !sda_oe);
endmodule

// File: tb/test_i2c_tri_target.sv
// Bench: bit-banged I2C master with a vector table, then directed cases.
module test_i2c_tri_target;
    logic clk = 1'b0, rst_n = 1'b0;
    logic strap_hi = 1'b1, strap_lo = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, sda_bus;
    int   n_chk = 0, n_err = 0;
    localparam int Q = 10;

    always #2 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_tri_target i_i2c_tri_target (
        .clk(clk), .rst_n(rst_n), .strap_hi(strap_hi), .strap_lo(strap_lo),
        .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic b_start(); m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq(); endtask
    task automatic b_stop();  m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(); endtask
    task automatic send_bit(input logic b); m_sda = b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq(); endtask
    task automatic recv_bit(output logic b); m_sda = 1; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq(); endtask

    task automatic tx_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b); ack = !b;
    endtask
    task automatic rx_byte(input logic last, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(last);
    endtask

    task automatic wr_frame(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d, output logic [2:0] acks);
        b_start(); tx_byte({a, 1'b0}, acks[2]); tx_byte(idx, acks[1]); tx_byte(d, acks[0]); b_stop();
    endtask
    task automatic rd_frame(input logic [6:0] a, input logic [7:0] idx, output logic [7:0] d, output logic [2:0] acks);
        b_start(); tx_byte({a, 1'b0}, acks[2]); tx_byte(idx, acks[1]);
        b_start(); tx_byte({a, 1'b1}, acks[0]); rx_byte(1'b1, d); b_stop();
    endtask

    // vector: rd, addr, index, data/expected, requirement number
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 7'h2E, 8'h10, 8'hA5, 4'd3},  // R3 write main space
        {1'b1, 7'h2E, 8'h10, 8'hA5, 4'd4},  // R4 read back
        {1'b1, 7'h2E, 8'h48, 8'h2E, 4'd2},  // R2 address register
        {1'b1, 7'h2E, 8'h4A, 8'h21, 4'd9},  // R9 config reset value
        {1'b0, 7'h49, 8'h01, 8'h3C, 4'd5},  // R5 bank A write
        {1'b1, 7'h49, 8'h01, 8'h3C, 4'd5},  // R5 bank A read
        {1'b1, 7'h49, 8'h05, 8'h3C, 4'd5},  // R5 index modulo 4
        {1'b1, 7'h2E, 8'h51, 8'h00, 4'd7},  // R7 window reads zero
        {1'b0, 7'h4A, 8'h02, 8'h77, 4'd6},  // R6 bank B write
        {1'b1, 7'h4A, 8'h02, 8'h77, 4'd6},  // R6 bank B read
        {1'b1, 7'h49, 8'h02, 8'h00, 4'd6},  // R6 bank A untouched
        {1'b0, 7'h2E, 8'h48, 8'h00, 4'd2},  // R2 write to address reg
        {1'b1, 7'h2E, 8'h48, 8'h2E, 4'd2}   // R2 still reads address
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d, d1, d2;
        logic       ack, b;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk("R9 sda released after reset", sda_oe, 0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][27]) begin
                rd_frame(VEC[v][26:20], VEC[v][19:12], d, acks);
                chk($sformatf("R%0d read acks v%0d", VEC[v][3:0], v), acks, 3'b111);
                chk($sformatf("R%0d read data v%0d", VEC[v][3:0], v), d, VEC[v][11:4]);
            end else begin
                wr_frame(VEC[v][26:20], VEC[v][19:12], VEC[v][11:4], acks);
                chk($sformatf("R%0d write acks v%0d", VEC[v][3:0], v), acks, 3'b111);
            end
        end

        // R7: main-address write into bank B window leaves bank B intact
        wr_frame(7'h2E, 8'h56, 8'hFF, acks);
        rd_frame(7'h4A, 8'h02, d, acks);
        chk("R7 bank B after window write", d, 8'h77);

        // R8: stranger address gets no ACK, SDA stays released
        b_start(); tx_byte(8'h60, ack);
        chk("R8 no ack on stranger", ack, 0);
        tx_byte(8'h10, ack);
        chk("R8 no ack on later byte", ack, 0);
        b_stop();

        // R4: burst write then burst read, NACK ends read
        b_start(); tx_byte({7'h2E, 1'b0}, ack); tx_byte(8'h20, ack);
        tx_byte(8'h11, ack); tx_byte(8'h22, ack); tx_byte(8'h33, ack); b_stop();
        b_start(); tx_byte({7'h2E, 1'b0}, ack); tx_byte(8'h20, ack);
        b_start(); tx_byte({7'h2E, 1'b1}, ack);
        rx_byte(1'b0, d); rx_byte(1'b0, d1); rx_byte(1'b1, d2);
        chk("R4 burst byte0", d, 8'h11);
        chk("R4 burst byte1", d1, 8'h22);
        chk("R4 burst byte2", d2, 8'h33);
        chk("R4 released after nack", sda_oe, 0);
        b_stop();

        // R11: pointers per address persist across frames
        wr_frame(7'h49, 8'h03, 8'h5A, acks);
        b_start(); tx_byte({7'h49, 1'b0}, ack); tx_byte(8'h03, ack); b_stop();
        b_start(); tx_byte({7'h2E, 1'b0}, ack); tx_byte(8'h30, ack); b_stop();
        b_start(); tx_byte({7'h49, 1'b1}, ack); rx_byte(1'b1, d); b_stop();
        chk("R11 own pointer kept", d, 8'h5A);

        // R10: reprogram auxiliary fields
        wr_frame(7'h2E, 8'h4A, 8'h53, acks);
        b_start(); tx_byte({7'h49, 1'b0}, ack); b_stop();
        chk("R10 old address no ack", ack, 0);
        rd_frame(7'h4B, 8'h01, d, acks);
        chk("R10 new second address", d, 8'h3C);
        rd_frame(7'h4D, 8'h02, d, acks);
        chk("R10 new third address", d, 8'h77);

        // R12: equal fields resolve to bank A
        wr_frame(7'h2E, 8'h4A, 8'h44, acks);
        wr_frame(7'h4C, 8'h02, 8'hC3, acks);
        wr_frame(7'h2E, 8'h4A, 8'h21, acks);
        rd_frame(7'h49, 8'h02, d, acks);
        chk("R12 tie went to bank A", d, 8'hC3);
        rd_frame(7'h4A, 8'h02, d, acks);
        chk("R12 bank B unchanged", d, 8'h77);

        // R1: straps moved after reset have no effect
        strap_hi = 0; strap_lo = 1;
        b_start(); tx_byte({7'h2E, 1'b0}, ack); b_stop();
        chk("R1 old main address still acks", ack, 1);
        b_start(); tx_byte({7'h2D, 1'b0}, ack); b_stop();
        chk("R1 new strap value ignored", ack, 0);

        // R1/R9: reset with new straps
        rst_n = 0; repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
        rd_frame(7'h2D, 8'h48, d, acks);
        chk("R1 main address after reset", d, 8'h2D);
        rd_frame(7'h2D, 8'h10, d, acks);
        chk("R9 general byte cleared", d, 8'h00);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule